// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo audio from a three-wire serial link (bit clock, word-select clock and serial data) and turns each serial word into a 24-bit two's-complement sample. Every sample carries a tag that names its channel. The three lines are treated as synchronous inputs and sampled on a faster system clock. A rising edge of the bit clock is detected inside the block, and each detected edge is one bit slot. A change of the word-select level at a slot marks a word boundary. At that boundary the word just finished is presented with a single-cycle valid strobe.

A static two-bit format input selects one of three framings:

- A standard inter-IC sound framing, where the data is delayed by one slot.
- A left-justified framing.
- A 16-bit right-justified framing.

The framings share one shift engine. Each framing differs in where the MSB or LSB sits relative to the word boundary, and in which word-select level means left. In the first two framings the word length follows the number of slots, so short words are padded with zeros and long words are cut. In the right-justified framing a sliding window keeps the last 16 bits before the boundary.

Top module: `srx_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `smp_valid`, `smp_data` and `smp_right` are all 0.
- R2: With `fmt_sel` = 2'b00, the MSB of a word is the bit sampled at the second bit-clock rise after a word-select change. The word's last bit is the one sampled at the rise where the next change is seen. Word-select low gives `smp_right` = 0 (left) and high gives `smp_right` = 1 (right).
- R3: With `fmt_sel` = 2'b01 (2'b11 behaves the same), the MSB is the bit sampled at the first rise after a word-select change. Word-select high gives `smp_right` = 0 (left) and low gives `smp_right` = 1.
- R4: In the modes of R2 and R3, a word of n < 24 bits appears in `smp_data[23:24-n]` and the lower 24-n bits are 0.
- R5: In the modes of R2 and R3, bits after the 24th bit of a word are discarded, and the first 24 bits are output unchanged.
- R6: With `fmt_sel` = 2'b10, the 16 bits sampled at the last 16 rises before a word-select change form the word, placed in `smp_data[23:8]`, with `smp_data[7:0]` = 0. Earlier bits of the half-frame are ignored. Word-select high gives `smp_right` = 0.
- R7: `smp_valid` is a one-cycle pulse issued once per completed word, at a word-select change. `smp_data` and `smp_right` change only together with it.
- R8: The word that ends at the first word-select change after reset is discarded and raises no strobe.
- R9: `fmt_sel` is taken only while `rst` is high or before the first word-select change. Later changes of `fmt_sel` have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 2 | Framing select: 00 inter-IC sound, 01/11 left-justified, 10 right-justified 16-bit |
| bclk | input | 1 | Serial bit clock, synchronous to clk |
| wsel | input | 1 | Word-select (channel) clock |
| sdata | input | 1 | Serial data, MSB first |
| smp_valid | output | 1 | One-cycle strobe for a new sample |
| smp_data | output | 24 | Received sample, two's complement, left-aligned |
| smp_right | output | 1 | Channel tag: 1 right, 0 left |

## Verification
The assertions assume the following about the inputs:

- `bclk` stays low and stays high for at least one system-clock cycle each.
- `wsel` and `sdata` are stable at the system-clock edge where `bclk` is first seen high.
- In the right-justified framing, every half-frame has at least 16 slots.

The stimulus meets these assumptions by construction. Inputs change only on falling system-clock edges. Each bit-clock phase lasts two system-clock cycles. Right-justified half-frames are drawn from 16 to 28 slots. `fmt_sel` moves mid-stream only in the runs that check that it is ignored.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_RSV = 2'b11
  } srx_fmt_e;

  typedef struct packed {
    logic rise;
    logic ws;
    logic sd;
  } srx_slot_t;

endpackage

// File: rtl/srx_line_sampler.sv
module srx_line_sampler
  import srx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      bclk,
  input  logic      wsel,
  input  logic      sdata,
  output srx_slot_t slot_o
);

  logic      bclk_q;
  srx_slot_t slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q <= 1'b1;
      slot_q <= '0;
    end else begin
      bclk_q      <= bclk;
      slot_q.rise <= bclk & ~bclk_q;
      slot_q.ws   <= wsel;
      slot_q.sd   <= sdata;
    end
  end

  assign slot_o = slot_q;

  // R7: bit-clock rise pulses are never back to back
  a_r7_rise_isolated: assert property (@(posedge clk) disable iff (rst)
    slot_q.rise |=> !slot_q.rise);

endmodule

// File: rtl/srx_frame_track.sv
module srx_frame_track
  import srx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  srx_slot_t slot_i,
  output logic      chg_o,
  output logic      primed_o,
  output logic      ws_old_o
);

  logic have_q;
  logic ws_q;
  logic primed_q;
  logic chg;

  always_comb chg = slot_i.rise && have_q && (slot_i.ws != ws_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q   <= 1'b0;
      ws_q     <= 1'b0;
      primed_q <= 1'b0;
    end else if (slot_i.rise) begin
      have_q <= 1'b1;
      ws_q   <= slot_i.ws;
      if (chg) primed_q <= 1'b1;
    end
  end

  assign chg_o    = chg;
  assign primed_o = primed_q;
  assign ws_old_o = ws_q;

  // R8: once armed, the block stays armed until reset
  a_r8_primed_sticky: assert property (@(posedge clk) disable iff (rst)
    primed_q |=> primed_q);

endmodule

// File: rtl/srx_word_shift.sv
module srx_word_shift
  import srx_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int RJ_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  srx_fmt_e          mode,
  input  logic              rise,
  input  logic              chg,
  input  logic              sd,
  output logic [WORD_W-1:0] word_o
);

  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] acc_ins;
  logic [CNT_W-1:0]  cnt_q;
  logic [RJ_W-1:0]   slide_q;
  logic [WORD_W-1:0] rj_word;
  logic              delayed;

  assign delayed = (mode == FMT_I2S);

  // accumulator with the current bit placed at its slot position
  always_comb begin
    acc_ins = acc_q;
    for (int i = 0; i < WORD_W; i++) begin
      if (cnt_q == CNT_W'(WORD_W - 1 - i)) acc_ins[i] = sd;
    end
  end

  generate
    if (WORD_W > RJ_W) begin : g_rj_pad
      assign rj_word = {slide_q, {(WORD_W - RJ_W){1'b0}}};
    end else if (WORD_W == RJ_W) begin : g_rj_same
      assign rj_word = slide_q;
    end else begin : g_rj_cut
      assign rj_word = slide_q[RJ_W-1 -: WORD_W];
    end
  endgenerate

  always_comb begin
    if (mode == FMT_RJ)  word_o = rj_word;
    else if (delayed)    word_o = acc_ins;
    else                 word_o = acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      slide_q <= '0;
    end else if (rise) begin
      slide_q <= {slide_q[RJ_W-2:0], sd};
      if (chg) begin
        if (delayed) begin
          acc_q <= '0;
          cnt_q <= '0;
        end else begin
          acc_q <= {sd, {(WORD_W - 1){1'b0}}};
          cnt_q <= CNT_W'(1);
        end
      end else begin
        acc_q <= acc_ins;
        if (cnt_q != CNT_W'(WORD_W)) cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R5: the bit position counter saturates at the word width
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(WORD_W));

  // R4: a fresh word starts from an all-zero tail
  a_r4_fresh_zero: assert property (@(posedge clk) disable iff (rst)
    (rise && chg) |=> (acc_q[WORD_W-2:0] == '0));

endmodule

// File: rtl/srx_top.sv
module srx_top
  import srx_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int RJ_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        fmt_sel,
  input  logic              bclk,
  input  logic              wsel,
  input  logic              sdata,
  output logic              smp_valid,
  output logic [WORD_W-1:0] smp_data,
  output logic              smp_right
);

  localparam int PAD_W = (WORD_W > RJ_W) ? WORD_W - RJ_W : 1;

  srx_slot_t         slot;
  srx_fmt_e          mode_q;
  logic              chg;
  logic              primed;
  logic              ws_old;
  logic              emit;
  logic [WORD_W-1:0] word;

  srx_line_sampler u_samp (
    .clk    (clk),
    .rst    (rst),
    .bclk   (bclk),
    .wsel   (wsel),
    .sdata  (sdata),
    .slot_o (slot)
  );

  srx_frame_track u_track (
    .clk      (clk),
    .rst      (rst),
    .slot_i   (slot),
    .chg_o    (chg),
    .primed_o (primed),
    .ws_old_o (ws_old)
  );

  srx_word_shift #(.WORD_W(WORD_W), .RJ_W(RJ_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode_q),
    .rise   (slot.rise),
    .chg    (chg),
    .sd     (slot.sd),
    .word_o (word)
  );

  // format is captured only during reset or before the first boundary
  always_ff @(posedge clk) begin
    if (rst || !primed) mode_q <= srx_fmt_e'(fmt_sel);
  end

  assign emit = chg && primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_valid <= 1'b0;
      smp_data  <= '0;
      smp_right <= 1'b0;
    end else begin
      smp_valid <= emit;
      if (emit) begin
        smp_data  <= word;
        smp_right <= (mode_q == FMT_I2S) ? ws_old : ~ws_old;
      end
    end
  end

  // R7: strobe lasts exactly one cycle
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid);

  // R7: sample fields move only together with the strobe
  a_r7_data_with_valid: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> ($stable(smp_data) && $stable(smp_right)) || smp_valid);

  // R8: no strobe unless a boundary had already been seen
  a_r8_no_early_valid: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> $past(primed));

  // R9: format is frozen once armed
  a_r9_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    primed |=> $stable(mode_q));

  // R6: right-justified samples have a clear low part
  a_r6_low_clear: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && mode_q == FMT_RJ) |-> (smp_data[PAD_W-1:0] == '0));

endmodule

// File: tb/tb_srx_top.sv
module tb_srx_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  fmt_sel = 2'b00;
  logic        bclk = 1'b0;
  logic        wsel = 1'b0;
  logic        sdata = 1'b0;
  logic        smp_valid;
  logic [23:0] smp_data;
  logic        smp_right;

  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  int          pulses = 0;
  logic        valid_prev = 1'b0;

  logic [24:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  srx_top dut (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .bclk(bclk), .wsel(wsel),
    .sdata(sdata), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_right(smp_right)
  );

  function automatic logic [23:0] exp_data(int mode, logic [23:0] w, int n);
    int nn;
    if (mode == 2) return {w[15:0], 8'h00};
    nn = (n > 24) ? 24 : n;
    return w & (24'hFFFFFF << (24 - nn));
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: every strobe is compared with the next expected sample
  always @(negedge clk) begin
    if (!rst && smp_valid) begin
      pulses++;
      check("R7 single-cycle strobe", {63'd0, valid_prev}, 64'd0);
      if (exp_q.size() == 0) begin
        check("R8 unexpected strobe", 64'd1, 64'd0);
      end else begin
        logic [24:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {39'd0, smp_right, smp_data}, {39'd0, e});
      end
    end
    valid_prev <= smp_valid;
  end

  task automatic drive_slot(logic ws, logic d);
    @(negedge clk);
    bclk = 1'b0; wsel = ws; sdata = d;
    @(negedge clk);
    @(negedge clk);
    bclk = 1'b1;
    @(negedge clk);
  endtask

  // mode: 0 I2S, 1 LJ, 2 RJ; sw_fmt >= 0 changes fmt_sel after half 2
  task automatic run(int mode, int nh, int lmin, int lmax, int sw_fmt);
    logic w0;
    logic prev_bit;
    int   start_pulses;
    @(negedge clk);
    rst = 1'b1; fmt_sel = 2'(mode); bclk = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q.delete(); tag_q.delete();
    start_pulses = pulses;
    w0 = 1'($urandom);
    prev_bit = 1'($urandom);
    for (int h = 0; h <= nh; h++) begin
      logic        ws;
      logic [23:0] w;
      int          n;
      ws = w0 ^ 1'(h & 1);
      n = (h == nh) ? 3 : lmin + int'($urandom % (lmax - lmin + 1));
      w = 24'($urandom);
      if (sw_fmt >= 0 && h == 2) fmt_sel = 2'(sw_fmt);
      for (int j = 0; j < n; j++) begin
        logic b;
        if (mode == 2)
          b = (j >= n - 16) ? w[15 - (j - (n - 16))] : 1'($urandom);
        else
          b = (j < 24) ? w[23 - j] : 1'($urandom);
        if (mode == 0) begin
          drive_slot(ws, prev_bit);
          prev_bit = b;
        end else begin
          drive_slot(ws, b);
        end
      end
      if (h >= 1 && h < nh) begin
        string t;
        if (sw_fmt >= 0)   t = "R9 format ignored after start";
        else if (mode == 2) t = "R6 right-justified word";
        else if (n < 24)   t = "R4 short word zero fill";
        else if (n > 24)   t = "R5 long word truncation";
        else if (mode == 0) t = "R2 delayed framing word";
        else               t = "R3 left-justified word";
        exp_q.push_back({(mode == 0) ? ws : ~ws, exp_data(mode, w, n)});
        tag_q.push_back(t);
      end
    end
    repeat (6) @(negedge clk);
    check("R7 all words delivered", 64'(exp_q.size()), 64'd0);
    check("R8 strobe count skips first word", 64'(pulses - start_pulses),
          64'(nh - 1));
  endtask

  initial begin
    void'($urandom(32'h5EED_A11D));
    repeat (2) @(negedge clk);
    check("R1 reset valid", {63'd0, smp_valid}, 64'd0);
    check("R1 reset data", {40'd0, smp_data}, 64'd0);
    check("R1 reset tag", {63'd0, smp_right}, 64'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release", {39'd0, smp_right, smp_data, smp_valid}, 64'd0);
    run(0, 30, 8, 30, -1);
    run(1, 30, 8, 30, -1);
    run(2, 30, 16, 28, -1);
    run(1, 8, 4, 4, -1);
    run(0, 8, 32, 32, -1);
    run(0, 8, 24, 24, -1);
    run(1, 8, 1, 3, -1);
    run(2, 12, 16, 20, 0);
    run(1, 12, 10, 26, 2);
    run(0, 12, 10, 26, 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule